// File: doc/BRIEF.md
# GPIO Bank with Change Interrupts

This block is a bank of general-purpose pins behind a byte-wide register port. A serial-bus slave, or any other register master, drives that port. Software sets each pin's direction and output level. It reads back the settled pin levels and learns which pins have toggled. Every pin has a change detector that fires on rising and on falling transitions. The detector records the event in a sticky status register whether or not that pin's interrupt is enabled. Reading the status register returns the recorded events and clears them.

Each input passes through a two-flop synchronizer and then a stable-count filter before edge comparison. Very short pulses are therefore discarded. A pin changes its filtered level only after the new value has been seen on `STABLE_CYCLES` consecutive clocks.

The interrupt line is modeled as an output enable plus a drive level. It becomes active when some recorded pin event is also enabled for that pin and the global enable is set. The drive level follows a programmable polarity. A control register also provides a self-clearing soft reset and an interface shutdown. Once shutdown is set, register traffic is dead until the hardware reset input is asserted.

Top module: `gpio_change_bank`

## Requirements
- R1: After `rst_n` is released, `pinOe`, `pinOut` and `irqOe` are 0. Reads of the direction (0x12), output (0x11), enable (0x08), control (0x02) and status (0x09) registers return 0x00.
- R2: Writing the direction register at 0x12 sets `pinOe`. A 1 bit makes that pin an output and a 0 bit makes it an input. The register reads back as written.
- R3: Writing the output register at 0x11 sets the `pinOut` levels. The register reads back as written.
- R4: A read of the monitor register at 0x10 returns the filtered pin levels. A level is accepted once `pinIn` has held it for `STABLE_CYCLES` consecutive clocks after synchronization. A pulse shorter than that is neither reflected in 0x10 nor recorded in 0x09.
- R5: A filtered LOW-to-HIGH or HIGH-to-LOW change on pin i sets bit i of the status register at 0x09, whether or not bit i of the enable register is set. The bit stays set until it is cleared.
- R6: A read of 0x09 returns the recorded change bits and clears them, which also withdraws the interrupt.
- R7: `irqOe` is 1 exactly when the status register ANDed with the enable register at 0x08 is nonzero and control bit 2 (global enable) is 1.
- R8: Control bit 0 selects polarity. While `irqOe` is 1, `irqLevel` is 1 when bit 0 is 1 (active high) and 0 when bit 0 is 0 (active low).
- R9: Writing control 0x02 with bit 7 set returns direction, output, enable, control and status to 0. Bit 7 then reads back as 0.
- R10: Writing control bit 1 as 1 raises `ifaceShutdown`. From then on, writes are ignored and every read returns 0x00 until `rst_n` is asserted.
- R11: Addresses other than 0x02, 0x08, 0x09, 0x10, 0x11 and 0x12 read as 0x00, and writes to them change nothing. Writes to 0x09 and 0x10 are also ignored.

Register read data is registered: it appears on `regRdData` in the cycle after `regRdEn` is sampled. Only control bits 0, 1 and 2 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe, one cycle per read |
| regRdData | output | 8 | Read data, valid the cycle after the strobe |
| pinIn | input | PIN_COUNT | Sampled pin levels |
| pinOe | output | PIN_COUNT | Per-pin output enable |
| pinOut | output | PIN_COUNT | Per-pin output level |
| irqOe | output | 1 | Interrupt line driven while 1 |
| irqLevel | output | 1 | Level driven on the interrupt line |
| ifaceShutdown | output | 1 | Register interface is shut down |

## Verification
The hardest case to reach is the filter boundary. A pin must toggle and then return before its count completes, and that glitch must leave both the monitor and status registers untouched. The stimulus therefore mixes full-length pin changes with single-cycle pulses on random bit sets. It checks status and interrupt state right after each one.

A second difficult state is an event that has been recorded while its enable bit is clear. To reach it, the random sequence writes enable and control values independently of pin activity. The interrupt line is checked after every operation, so masked events become visible the moment an enable is written.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [7:0] ADDR_SYS  = 8'h02;
  localparam logic [7:0] ADDR_IEN  = 8'h08;
  localparam logic [7:0] ADDR_STAT = 8'h09;
  localparam logic [7:0] ADDR_MON  = 8'h10;
  localparam logic [7:0] ADDR_OUT  = 8'h11;
  localparam logic [7:0] ADDR_DIR  = 8'h12;

  // control register bit positions
  localparam int SYS_POL   = 0;
  localparam int SYS_SHDN  = 1;
  localparam int SYS_GIEN  = 2;
  localparam int SYS_SRST  = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SYS,
    SEL_IEN,
    SEL_STAT,
    SEL_MON,
    SEL_OUT,
    SEL_DIR
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrOut;
    logic   wrIen;
    logic   wrSys;
    logic   softRst;
    logic   rdStat;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  input  logic       srstBit,
  input  logic       regRdEn,
  input  logic       shutdown,
  output strobes_t   strobes
);

  logic wrOk;
  logic rdOk;
  rdSel_e sel;

  assign wrOk = regWrEn && !shutdown;
  assign rdOk = regRdEn && !shutdown;

  always_comb begin
    case (regAddr)
      ADDR_SYS:  sel = SEL_SYS;
      ADDR_IEN:  sel = SEL_IEN;
      ADDR_STAT: sel = SEL_STAT;
      ADDR_MON:  sel = SEL_MON;
      ADDR_OUT:  sel = SEL_OUT;
      ADDR_DIR:  sel = SEL_DIR;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes         = '0;
    strobes.wrDir   = wrOk && (sel == SEL_DIR);
    strobes.wrOut   = wrOk && (sel == SEL_OUT);
    strobes.wrIen   = wrOk && (sel == SEL_IEN);
    strobes.wrSys   = wrOk && (sel == SEL_SYS) && !srstBit;
    strobes.softRst = wrOk && (sel == SEL_SYS) && srstBit;
    strobes.rdStat  = rdOk && (sel == SEL_STAT);
    // a read while shut down still updates the data register, with zero
    strobes.rdEn    = regRdEn;
    strobes.rdSel   = rdOk ? sel : SEL_NONE;
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT     = 8,
  parameter int STABLE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobes_t             strobes,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic                 irqOe,
  output logic                 irqLevel,
  output logic                 shutdown,
  output logic [PIN_COUNT-1:0] statusQ,
  output logic [PIN_COUNT-1:0] ienQ,
  output logic [2:0]           sysQ
);

  localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] outQ;
  logic [PIN_COUNT-1:0] syncA;
  logic [PIN_COUNT-1:0] syncB;
  logic [PIN_COUNT-1:0] filtLvl;
  logic [PIN_COUNT-1:0] chgEvt;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // per-pin stable-count filter; the filtered level moves only after
  // STABLE_CYCLES matching samples, and that move is the change event
  for (genvar i = 0; i < PIN_COUNT; i++) begin : gFilt
    logic [CNT_W-1:0] cnt;
    logic             lvl;
    logic             differ;

    assign differ = syncB[i] != lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (differ) begin
        if (cnt == CNT_LAST) begin
          lvl <= syncB[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end

    assign filtLvl[i] = lvl;
    assign chgEvt[i]  = differ && (cnt == CNT_LAST);
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirQ <= '0;
      outQ <= '0;
      ienQ <= '0;
      sysQ <= '0;
    end else if (strobes.softRst) begin
      dirQ <= '0;
      outQ <= '0;
      ienQ <= '0;
      sysQ <= '0;
    end else begin
      if (strobes.wrDir) dirQ <= regWrData[PIN_COUNT-1:0];
      if (strobes.wrOut) outQ <= regWrData[PIN_COUNT-1:0];
      if (strobes.wrIen) ienQ <= regWrData[PIN_COUNT-1:0];
      if (strobes.wrSys) sysQ <= {regWrData[SYS_GIEN], regWrData[SYS_SHDN],
                                  regWrData[SYS_POL]};
    end
  end

  // sticky change status, cleared by reading it; a same-cycle event survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
    end else if (strobes.softRst) begin
      statusQ <= '0;
    end else begin
      statusQ <= (strobes.rdStat ? '0 : statusQ) | chgEvt;
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regRdData <= '0;
    end else if (strobes.rdEn) begin
      regRdData <= '0;
      case (strobes.rdSel)
        SEL_SYS:  regRdData <= {5'b0, sysQ};
        SEL_IEN:  regRdData[PIN_COUNT-1:0] <= ienQ;
        SEL_STAT: regRdData[PIN_COUNT-1:0] <= statusQ;
        SEL_MON:  regRdData[PIN_COUNT-1:0] <= filtLvl;
        SEL_OUT:  regRdData[PIN_COUNT-1:0] <= outQ;
        SEL_DIR:  regRdData[PIN_COUNT-1:0] <= dirQ;
        default:  regRdData <= '0;
      endcase
    end
  end

  assign pinOe    = dirQ;
  assign pinOut   = outQ;
  assign shutdown = sysQ[1];
  assign irqOe    = sysQ[2] && |(statusQ & ienQ);
  assign irqLevel = sysQ[0];

endmodule

// File: rtl/gpio_change_bank.sv
module gpio_change_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT     = 8,
  parameter int STABLE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [7:0]           regWrData,
  input  logic                 regRdEn,
  output logic [7:0]           regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic                 irqOe,
  output logic                 irqLevel,
  output logic                 ifaceShutdown
);

  strobes_t             strobes;
  logic [PIN_COUNT-1:0] statusQ;
  logic [PIN_COUNT-1:0] ienQ;
  logic [2:0]           sysQ;

  gpio_bank_ctrl uCtrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .srstBit  (regWrData[SYS_SRST]),
    .regRdEn  (regRdEn),
    .shutdown (ifaceShutdown),
    .strobes  (strobes)
  );

  gpio_bank_datapath #(
    .PIN_COUNT     (PIN_COUNT),
    .STABLE_CYCLES (STABLE_CYCLES)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pinIn     (pinIn),
    .pinOe     (pinOe),
    .pinOut    (pinOut),
    .irqOe     (irqOe),
    .irqLevel  (irqLevel),
    .shutdown  (ifaceShutdown),
    .statusQ   (statusQ),
    .ienQ      (ienQ),
    .sysQ      (sysQ)
  );

endmodule

// File: rtl/gpio_change_bank_checker.sv
module gpio_change_bank_checker #(
  parameter int PIN_COUNT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           regAddr,
  input logic                 regWrEn,
  input logic [7:0]           regWrData,
  input logic                 regRdEn,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic                 irqOe,
  input logic                 irqLevel,
  input logic                 ifaceShutdown,
  input logic [PIN_COUNT-1:0] statusQ,
  input logic [PIN_COUNT-1:0] ienQ,
  input logic [2:0]           sysQ
);

  logic statRead;
  logic cfgWrite;
  logic srstWrite;

  assign statRead  = regRdEn && (regAddr == 8'h09) && !ifaceShutdown;
  assign cfgWrite  = regWrEn && (regAddr == 8'h12 || regAddr == 8'h02) && !ifaceShutdown;
  assign srstWrite = regWrEn && (regAddr == 8'h02) && regWrData[7] && !ifaceShutdown;

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWrite |=> $stable(pinOe));

  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!statRead && !srstWrite) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irqOe |-> (sysQ[2] && ((statusQ & ienQ) != '0)));

  assert_softreset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srstWrite |=> (pinOe == '0 && pinOut == '0 && !irqOe && sysQ == 3'b000));

  assert_shutdown_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ifaceShutdown |=> (ifaceShutdown && $stable(pinOe) && $stable(pinOut)));

  assert_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOe && !$stable(irqLevel)) |-> ($past(regWrEn) && $past(regAddr) == 8'h02));

endmodule

bind gpio_change_bank gpio_change_bank_checker #(.PIN_COUNT(PIN_COUNT)) uChk (
  .clk           (clk),
  .rst_n         (rst_n),
  .regAddr       (regAddr),
  .regWrEn       (regWrEn),
  .regWrData     (regWrData),
  .regRdEn       (regRdEn),
  .pinOe         (pinOe),
  .pinOut        (pinOut),
  .irqOe         (irqOe),
  .irqLevel      (irqLevel),
  .ifaceShutdown (ifaceShutdown),
  .statusQ       (statusQ),
  .ienQ          (ienQ),
  .sysQ          (sysQ)
);

// File: tb/gpio_change_bank_test.sv
`timescale 1ns/1ps
module gpio_change_bank_test;

  localparam int PINS   = 8;
  localparam int STABLE = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [7:0]      regWrData = '0;
  logic            regRdEn = 1'b0;
  logic [7:0]      regRdData;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOe;
  logic [PINS-1:0] pinOut;
  logic            irqOe;
  logic            irqLevel;
  logic            ifaceShutdown;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  logic [7:0] refDir, refOut, refIen, refStat, refLvl;
  logic [2:0] refSys;

  always #10 clk = ~clk;

  gpio_change_bank #(.PIN_COUNT(PINS), .STABLE_CYCLES(STABLE)) uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut), .irqOe(irqOe),
    .irqLevel(irqLevel), .ifaceShutdown(ifaceShutdown)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [7:0] a);
    case (a)
      8'h02:   return {5'b0, refSys};
      8'h08:   return refIen;
      8'h09:   return refStat;
      8'h10:   return refLvl;
      8'h11:   return refOut;
      8'h12:   return refDir;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic expIrq();
    return refSys[2] && ((refStat & refIen) != 8'h00);
  endfunction

  task automatic clearRef();
    refDir = '0; refOut = '0; refIen = '0; refStat = '0; refSys = '0;
  endtask

  task automatic checkIrq(string tag);
    check({tag, " R7 irqOe"}, {7'b0, irqOe}, {7'b0, expIrq()});
    if (irqOe) check({tag, " R8 irqLevel"}, {7'b0, irqLevel}, {7'b0, refSys[0]});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      8'h02: if (d[7]) clearRef(); else refSys = d[2:0];
      8'h08: refIen = d;
      8'h11: refOut = d;
      8'h12: refDir = d;
      default: ;
    endcase
  endtask

  task automatic rdCheck(logic [7:0] a, string req);
    logic [7:0] exp;
    exp = expRead(a);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, regRdData, exp);
    if (a == 8'h09) refStat = '0;
  endtask

  task automatic setPins(logic [7:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (STABLE + 4) @(negedge clk);
    refStat = refStat | (refLvl ^ v);
    refLvl  = v;
  endtask

  task automatic glitch(logic [7:0] m);
    @(negedge clk);
    pinIn = refLvl ^ m;
    @(negedge clk);
    pinIn = refLvl;
    repeat (STABLE + 4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] r;
    void'($urandom(32'd2024));
    clearRef(); refLvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 irqOe", {7'b0, irqOe}, 8'h00);
    rdCheck(8'h12, "R1 dir");
    rdCheck(8'h11, "R1 out");
    rdCheck(8'h08, "R1 ien");
    rdCheck(8'h02, "R1 sys");
    rdCheck(8'h09, "R1 status");

    // R2 / R3 direction and output
    wr(8'h12, 8'hA5); check("R2 pinOe", pinOe, 8'hA5); rdCheck(8'h12, "R2 dir readback");
    wr(8'h11, 8'h3C); check("R3 pinOut", pinOut, 8'h3C); rdCheck(8'h11, "R3 out readback");

    // R5 masked change is still recorded, R4 monitor
    setPins(8'h81);
    rdCheck(8'h10, "R4 monitor");
    checkIrq("R5 masked");
    rdCheck(8'h09, "R5 status both edges");
    setPins(8'h01);
    // R4 short pulse ignored
    glitch(8'h7E);
    rdCheck(8'h10, "R4 glitch monitor");
    rdCheck(8'h09, "R4 glitch status");

    // R7 / R8 interrupt gating and polarity
    wr(8'h08, 8'h02);
    setPins(8'h03);
    checkIrq("R7 no global");
    wr(8'h02, 8'h05);
    checkIrq("R8 active high");
    wr(8'h02, 8'h04);
    checkIrq("R8 active low");
    rdCheck(8'h09, "R6 read clears");
    checkIrq("R6 after clear");
    rdCheck(8'h09, "R6 empty");

    // R11 unused and read-only addresses
    wr(8'h33, 8'hFF); wr(8'h09, 8'hFF); wr(8'h10, 8'hFF);
    rdCheck(8'h33, "R11 unused read");
    rdCheck(8'h09, "R11 status unchanged");
    check("R11 pinOe", pinOe, refDir);

    // R9 soft reset
    wr(8'h12, 8'hFF); wr(8'h08, 8'hFF);
    wr(8'h02, 8'h85);
    check("R9 pinOe", pinOe, 8'h00);
    rdCheck(8'h02, "R9 sys self-clear");
    rdCheck(8'h08, "R9 ien");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      r = 8'($urandom_range(0, 9));
      case (r)
        0: wr(8'h12, 8'($urandom));
        1: wr(8'h11, 8'($urandom));
        2: wr(8'h08, 8'($urandom));
        3: wr(8'h02, ($urandom_range(0, 15) == 0) ? 8'h80 : (8'($urandom) & 8'h7D));
        4: setPins(8'($urandom));
        5: glitch(8'($urandom) | 8'h01);
        6: rdCheck(8'h09, "R6 random status");
        7: rdCheck(8'h10, "R4 random monitor");
        8: begin
          logic [7:0] a;
          a = 8'($urandom);
          rdCheck(a, "R11 random read");
        end
        default: wr(8'($urandom_range(32, 255)), 8'($urandom));
      endcase
      checkIrq("R7 random");
      check("R2 random pinOe", pinOe, refDir);
      check("R3 random pinOut", pinOut, refOut);
    end

    // R10 shutdown until hard reset
    wr(8'h12, 8'h0F);
    @(negedge clk); regAddr = 8'h02; regWrData = 8'h02; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    check("R10 flag", {7'b0, ifaceShutdown}, 8'h01);
    @(negedge clk); regAddr = 8'h12; regWrData = 8'hF0; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    check("R10 write ignored", pinOe, 8'h0F);
    @(negedge clk); regAddr = 8'h12; regRdEn = 1'b1;
    @(negedge clk); regRdEn = 1'b0;
    check("R10 read zero", regRdData, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clearRef();
    check("R10 released", {7'b0, ifaceShutdown}, 8'h00);
    check("R1 pinOe after reset", pinOe, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule